// File: doc/BRIEF.md
# Card Command Issue and Response Capture Engine

This block sits between a register bus and a memory-card model. Software loads a 32-bit command argument and then writes a command word. That word holds a 6-bit command index, a response request, a long-response request and a go bit. While the engine is idle, a write with the go bit set starts a request to the card side. The engine latches the index and the argument, raises a request line, and waits in a busy state until the card side acknowledges. With the acknowledge, the card side returns an error flag, a response length in bytes and up to sixteen response bytes.

The engine checks the returned length against the response type that was requested. An unsuitable length is reported as a timeout. A good response is packed big-endian into four 32-bit response words. The engine then sets one sticky status bit: command sent, response received, or timeout. Software clears status bits through a write-one-to-clear register. Two interrupt lines each assert while any status bit is also set in that line's own mask register.

Top module: `cmdeng_top`

## Requirements
- R1: Word addresses are: 0 argument, 1 command, 2 to 5 response words 0 to 3, 6 status, 7 clear (reads 0), 8 mask for irq[0], 9 mask for irq[1]. Any other address reads 0. Command bits are: 5:0 index, 6 response wanted, 7 long response, 8 interrupt mode, 9 pending mode, 10 go. Only bits 10:0 of the command are stored. A command write with bit 10 set and bit 9 clear, made while idle, raises card_req on the next cycle. card_idx then equals bits 5:0 and card_arg equals the argument register. Both hold steady until card_ack.
- R2: From the start of a command until the cycle after card_ack, status bit 11 reads 1 and the command register reads with bit 10 set. In the cycle after card_ack, card_req, status bit 11 and command bit 10 are all 0.
- R3: A write to the command register while a command is busy changes neither the command register nor the card request.
- R4: When no response was requested, an acknowledge without error sets status bit 7 (command sent). An acknowledge with error sets status bit 2 (timeout). The response words are left unchanged in both cases.
- R5: When a response was requested, the command ends as a timeout (status bit 2) and the response words are left unchanged in any of these cases: the error flag is set; the length is 0; the length is 4 while a long response was requested; the length is anything other than 4 or 16.
- R6: A valid 4-byte response sets status bit 6. It loads response word 0 with card_rsp[127:96], so byte 0 of the response lands in bits 31:24. It clears words 1 to 3.
- R7: A valid 16-byte response sets status bit 6 and loads words 0 to 3 from card_rsp[127:96], [95:64], [63:32] and [31:0], with bit 0 of word 3 forced to 0. A 16-byte response is also accepted when only a short response was requested.
- R8: A go write with bit 9 (pending mode) set issues no request and sets no status bit. It stores the command with bit 10 cleared. Bit 8 (interrupt mode) has no effect on issue.
- R9: A write to the clear register clears only those status bits that are set in bits 10:0 of the written value. If a command completes in the same cycle, the status bit it sets still ends up set.
- R10: irq[i] is high exactly when the status word ANDed with mask register i is nonzero. This includes the live bit 11.
- R11: After reset, all registers read 0, card_req is low and both interrupt lines are low.
- R12: card_ack while no command is busy changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| card_req | output | 1 | Command request to the card side, held until acknowledge |
| card_idx | output | 6 | Command index of the pending request |
| card_arg | output | 32 | Command argument of the pending request |
| card_ack | input | 1 | One-cycle acknowledge from the card side |
| card_err | input | 1 | Card reported an error, valid with card_ack |
| card_len | input | LEN_W | Response length in bytes, valid with card_ack |
| card_rsp | input | 32*RSP_WORDS | Response bytes, byte 0 in the top bits, valid with card_ack |
| irq | output | NUM_IRQ | Masked status interrupt lines |

## Verification
The bench builds the engine with its defaults: two interrupt lines, four response words and a 4-bit word address. These defaults reach every decoded address, both mask registers and the full 16-byte response path, including the forced low bit of the last word. Because the length port is 5 bits wide, the bench can drive the rejected lengths 0, 8 and 17 alongside the valid 4 and 16. The bench also places a clear write in the same cycle as an acknowledge, and sends an acknowledge while the engine is idle.

// File: rtl/cmdeng_pkg.sv
// Shared constants and types for the command engine.
// Assumes word-addressed registers and 32-bit data.
package cmdeng_pkg;
    // register word addresses
    localparam int A_ARG   = 0;
    localparam int A_CMD   = 1;
    localparam int A_RSP0  = 2;
    localparam int A_STAT  = 6;
    localparam int A_CLR   = 7;
    localparam int A_MASK0 = 8;

    // command word fields
    localparam int CMD_W    = 11;
    localparam int B_WANT   = 6;
    localparam int B_LONG   = 7;
    localparam int B_PEND   = 9;
    localparam int B_GO     = 10;

    // status bits
    localparam int B_TOUT   = 2;
    localparam int B_RESP   = 6;
    localparam int B_SENT   = 7;
    localparam int B_ACTIVE = 11;
    localparam int STICKY_W = 11;

    localparam int SHORT_BYTES = 4;

    typedef enum logic [1:0] {RES_SENT, RES_RESP, RES_TOUT} res_e;
    typedef enum logic {ST_IDLE, ST_BUSY} st_e;
endpackage

// File: rtl/cmdeng_seq.sv
// Command sequencer: latches index and argument on start, holds the
// card request until acknowledge, classifies the outcome and packs the
// response words. Assumes card_ack is a single-cycle pulse.
module cmdeng_seq
    import cmdeng_pkg::*;
#(
    parameter  int RSP_WORDS = 4,
    localparam int RSP_BITS  = RSP_WORDS * 32,
    localparam int LONG_BYTES = RSP_WORDS * 4,
    localparam int LEN_W     = $clog2(LONG_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [5:0]           start_idx,
    input  logic [31:0]          start_arg,
    input  logic                 start_want,
    input  logic                 start_long,
    output logic                 busy,
    output logic                 done,
    output res_e                 result,
    output logic [RSP_WORDS-1:0][31:0] rsp_words,
    output logic                 card_req,
    output logic [5:0]           card_idx,
    output logic [31:0]          card_arg,
    input  logic                 card_ack,
    input  logic                 card_err,
    input  logic [LEN_W-1:0]     card_len,
    input  logic [RSP_BITS-1:0]  card_rsp
);
    st_e         state_q;
    logic [5:0]  idx_q;
    logic [31:0] arg_q;
    logic        want_q;
    logic        long_q;
    logic        short_len;
    logic        long_len;

    // state and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            arg_q   <= '0;
            want_q  <= 1'b0;
            long_q  <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                state_q <= ST_BUSY;
                idx_q   <= start_idx;
                arg_q   <= start_arg;
                want_q  <= start_want;
                long_q  <= start_long;
            end
        end else if (card_ack) begin
            state_q <= ST_IDLE;
        end
    end

    assign busy     = (state_q == ST_BUSY);
    assign done     = busy && card_ack;
    assign card_req = busy;
    assign card_idx = idx_q;
    assign card_arg = arg_q;

    assign short_len = (card_len == LEN_W'(SHORT_BYTES));
    assign long_len  = (card_len == LEN_W'(LONG_BYTES));

    // outcome classification
    always_comb begin
        if (!want_q)
            result = card_err ? RES_TOUT : RES_SENT;
        else if (card_err || !(short_len || long_len) || (short_len && long_q))
            result = RES_TOUT;
        else
            result = RES_RESP;
    end

    // big-endian word packing per response word
    for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
        logic [31:0] raw;
        assign raw = card_rsp[RSP_BITS-1-32*w -: 32];
        if (w == 0) begin : g_first
            assign rsp_words[w] = raw;
        end else if (w == RSP_WORDS - 1) begin : g_last
            assign rsp_words[w] = short_len ? 32'h0 : {raw[31:1], 1'b0};
        end else begin : g_mid
            assign rsp_words[w] = short_len ? 32'h0 : raw;
        end
    end
endmodule

// File: rtl/cmdeng_regs.sv
// Register file: argument, command, response words, sticky status with
// write-one-to-clear, and per-line masks. Decodes the start condition.
// Assumes at most one write per cycle and reads without side effects.
module cmdeng_regs
    import cmdeng_pkg::*;
#(
    parameter int NUM_IRQ   = 2,
    parameter int RSP_WORDS = 4,
    parameter int ADDR_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [31:0]                wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [31:0]                rd_data,
    input  logic                       busy,
    input  logic                       done,
    input  res_e                       result,
    input  logic [RSP_WORDS-1:0][31:0] rsp_words,
    output logic                       start,
    output logic [5:0]                 start_idx,
    output logic [31:0]                start_arg,
    output logic                       start_want,
    output logic                       start_long,
    output logic [31:0]                stat_out,
    output logic [NUM_IRQ-1:0][31:0]   mask_out
);
    logic [31:0]                 arg_q;
    logic [CMD_W-1:0]            cmd_q;
    logic [RSP_WORDS-1:0][31:0]  rsp_q;
    logic [STICKY_W-1:0]         stat_q;
    logic [NUM_IRQ-1:0][31:0]    mask_q;
    logic                        wr_cmd;
    logic [STICKY_W-1:0]         clr_bits;
    logic [STICKY_W-1:0]         set_bits;

    assign wr_cmd     = wr_en && (int'(wr_addr) == A_CMD);
    assign start      = wr_cmd && !busy && wr_data[B_GO] && !wr_data[B_PEND];
    assign start_idx  = wr_data[5:0];
    assign start_arg  = arg_q;
    assign start_want = wr_data[B_WANT];
    assign start_long = wr_data[B_LONG];

    // argument register
    always_ff @(posedge clk) begin
        if (!rst_n)
            arg_q <= '0;
        else if (wr_en && int'(wr_addr) == A_ARG)
            arg_q <= wr_data;
    end

    // command register; go bit self-clears on completion or pending mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (wr_cmd && !busy)
            cmd_q <= {wr_data[B_GO] & ~wr_data[B_PEND], wr_data[B_GO-1:0]};
        else if (done)
            cmd_q[B_GO] <= 1'b0;
    end

    // response words load on a successful response
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_q <= '0;
        else if (done && result == RES_RESP)
            rsp_q <= rsp_words;
    end

    // status clear and set terms
    always_comb begin
        clr_bits = '0;
        set_bits = '0;
        if (wr_en && int'(wr_addr) == A_CLR)
            clr_bits = wr_data[STICKY_W-1:0];
        if (done) begin
            case (result)
                RES_SENT: set_bits[B_SENT] = 1'b1;
                RES_RESP: set_bits[B_RESP] = 1'b1;
                default:  set_bits[B_TOUT] = 1'b1;
            endcase
        end
    end

    // sticky status; a completion in the same cycle wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~clr_bits) | set_bits;
    end

    // one mask register per interrupt line
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[i] <= '0;
            else if (wr_en && int'(wr_addr) == A_MASK0 + i)
                mask_q[i] <= wr_data;
        end
    end

    assign stat_out = {{(31-B_ACTIVE){1'b0}}, busy, stat_q};
    assign mask_out = mask_q;

    // read multiplexer
    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) == A_ARG)  rd_data = arg_q;
        if (int'(rd_addr) == A_CMD)  rd_data = {{(32-CMD_W){1'b0}}, cmd_q};
        if (int'(rd_addr) == A_STAT) rd_data = stat_out;
        for (int w = 0; w < RSP_WORDS; w++)
            if (int'(rd_addr) == A_RSP0 + w) rd_data = rsp_q[w];
        for (int i = 0; i < NUM_IRQ; i++)
            if (int'(rd_addr) == A_MASK0 + i) rd_data = mask_q[i];
    end
endmodule

// File: rtl/cmdeng_irq.sv
// Interrupt reduction: each line is the OR of status AND its mask.
// Assumes status and masks come straight from registers.
module cmdeng_irq #(
    parameter int NUM_IRQ = 2
) (
    input  logic [31:0]              stat,
    input  logic [NUM_IRQ-1:0][31:0] mask,
    output logic [NUM_IRQ-1:0]       irq
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        // reduce one masked status word to a line
        assign irq[i] = |(stat & mask[i]);
    end
endmodule

// File: rtl/cmdeng_top.sv
// Command issue and response capture engine top level.
// Connects register file, sequencer and interrupt reduction.
// Assumes the card side holds its response inputs valid with card_ack.
module cmdeng_top
    import cmdeng_pkg::*;
#(
    parameter  int NUM_IRQ   = 2,
    parameter  int RSP_WORDS = 4,
    parameter  int ADDR_W    = 4,
    localparam int RSP_BITS  = RSP_WORDS * 32,
    localparam int LEN_W     = $clog2(RSP_WORDS * 4 + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [31:0]         wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [31:0]         rd_data,
    output logic                card_req,
    output logic [5:0]          card_idx,
    output logic [31:0]         card_arg,
    input  logic                card_ack,
    input  logic                card_err,
    input  logic [LEN_W-1:0]    card_len,
    input  logic [RSP_BITS-1:0] card_rsp,
    output logic [NUM_IRQ-1:0]  irq
);
    logic                       busy_w;
    logic                       done_w;
    res_e                       result_w;
    logic [RSP_WORDS-1:0][31:0] rsp_words_w;
    logic                       start_w;
    logic [5:0]                 start_idx_w;
    logic [31:0]                start_arg_w;
    logic                       start_want_w;
    logic                       start_long_w;
    logic [31:0]                stat_w;
    logic [NUM_IRQ-1:0][31:0]   mask_w;

    cmdeng_regs #(.NUM_IRQ(NUM_IRQ), .RSP_WORDS(RSP_WORDS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy_w), .done(done_w), .result(result_w), .rsp_words(rsp_words_w),
        .start(start_w), .start_idx(start_idx_w), .start_arg(start_arg_w),
        .start_want(start_want_w), .start_long(start_long_w),
        .stat_out(stat_w), .mask_out(mask_w)
    );

    cmdeng_seq #(.RSP_WORDS(RSP_WORDS)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .start_idx(start_idx_w), .start_arg(start_arg_w),
        .start_want(start_want_w), .start_long(start_long_w),
        .busy(busy_w), .done(done_w), .result(result_w), .rsp_words(rsp_words_w),
        .card_req(card_req), .card_idx(card_idx), .card_arg(card_arg),
        .card_ack(card_ack), .card_err(card_err), .card_len(card_len),
        .card_rsp(card_rsp)
    );

    cmdeng_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .stat(stat_w), .mask(mask_w), .irq(irq)
    );
endmodule

// File: rtl/cmdeng_chk.sv
// Protocol and status checker bound to the command engine top level.
module cmdeng_chk
    import cmdeng_pkg::*;
#(
    parameter int NUM_IRQ = 2,
    parameter int ADDR_W  = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [31:0]              wr_data,
    input logic                     card_req,
    input logic                     card_ack,
    input logic [5:0]               card_idx,
    input logic [31:0]              card_arg,
    input logic [31:0]              stat,
    input logic [NUM_IRQ-1:0][31:0] mask,
    input logic [NUM_IRQ-1:0]       irq
);
    // R1: request stays up until acknowledged
    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        card_req && !card_ack |=> card_req);

    // R1: index and argument are steady while waiting
    p_req_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        card_req && !card_ack |=> $stable(card_idx) && $stable(card_arg));

    // R2: active status tracks an outstanding request
    p_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        card_req |-> stat[B_ACTIVE]);

    // R2: acknowledge ends the request
    p_ack_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        card_req && card_ack |=> !card_req && !stat[B_ACTIVE]);

    // R4: each completion leaves an outcome bit set
    p_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        card_req && card_ack |=> (stat[B_TOUT] || stat[B_RESP] || stat[B_SENT]));

    // R8: pending-mode go write issues nothing
    p_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && int'(wr_addr) == A_CMD && wr_data[B_GO] && wr_data[B_PEND] && !card_req
        |=> !card_req);

    // R9: clearing the sent bit works when no completion collides
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && int'(wr_addr) == A_CLR && wr_data[B_SENT] && !(card_req && card_ack)
        |=> !stat[B_SENT]);

    // R10: a zero mask keeps its line low
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq_chk
        p_zero_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (mask[i] == 32'h0) |-> !irq[i]);
    end
endmodule

bind cmdeng_top cmdeng_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .card_req(card_req), .card_ack(card_ack), .card_idx(card_idx), .card_arg(card_arg),
    .stat(stat_w), .mask(mask_w), .irq(irq)
);

// File: tb/cmdeng_top_tb.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module cmdeng_top_tb;
    localparam int NIRQ = 2;
    localparam int AW   = 4;
    localparam int LW   = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]  rd_data;
    logic         card_req;
    logic [5:0]   card_idx;
    logic [31:0]  card_arg;
    logic         card_ack = 1'b0;
    logic         card_err = 1'b0;
    logic [LW-1:0] card_len = '0;
    logic [127:0] card_rsp = '0;
    logic [NIRQ-1:0] irq;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cmdeng_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .card_req(card_req), .card_idx(card_idx),
        .card_arg(card_arg), .card_ack(card_ack), .card_err(card_err),
        .card_len(card_len), .card_rsp(card_rsp), .irq(irq)
    );

    // reference model state
    bit [31:0] m_arg, m_cmd, m_stat, m_argl;
    bit [31:0] m_rsp [4];
    bit [31:0] m_mask [NIRQ];
    bit        m_busy;
    bit [5:0]  m_idx;

    function automatic bit [31:0] m_read(int a);
        if (a == 0) return m_arg;
        if (a == 1) return m_cmd;
        if (a >= 2 && a <= 5) return m_rsp[a-2];
        if (a == 6) return m_stat | (32'(m_busy) << 11);
        if (a >= 8 && a < 8 + NIRQ) return m_mask[a-8];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_arg = 0; m_cmd = 0; m_stat = 0; m_argl = 0; m_busy = 0; m_idx = 0;
            foreach (m_rsp[k]) m_rsp[k] = 0;
            foreach (m_mask[k]) m_mask[k] = 0;
        end else begin
            bit pre_busy;
            pre_busy = m_busy;
            if (wr_en && wr_addr == 7) m_stat = m_stat & ~(wr_data & 32'h7ff);
            if (pre_busy && card_ack) begin
                int n;
                n = int'(card_len);
                if (!m_cmd[6]) begin
                    m_stat[card_err ? 2 : 7] = 1'b1;
                end else if (card_err || !(n == 4 || n == 16) || (n == 4 && m_cmd[7])) begin
                    m_stat[2] = 1'b1;
                end else begin
                    m_stat[6] = 1'b1;
                    m_rsp[0] = card_rsp[127:96];
                    if (n == 4) begin
                        m_rsp[1] = 0; m_rsp[2] = 0; m_rsp[3] = 0;
                    end else begin
                        m_rsp[1] = card_rsp[95:64];
                        m_rsp[2] = card_rsp[63:32];
                        m_rsp[3] = card_rsp[31:0] & ~32'h1;
                    end
                end
                m_cmd[10] = 1'b0;
                m_busy = 0;
            end
            if (wr_en) begin
                if (wr_addr == 0) m_arg = wr_data;
                if (wr_addr == 1 && !pre_busy) begin
                    m_cmd = wr_data & 32'h7ff;
                    if (wr_data[10] && !wr_data[9]) begin
                        m_busy = 1; m_idx = wr_data[5:0]; m_argl = m_arg;
                    end else begin
                        m_cmd[10] = 1'b0;
                    end
                end
                for (int k = 0; k < NIRQ; k++)
                    if (int'(wr_addr) == 8 + k) m_mask[k] = wr_data;
            end
        end
    end

    // per-cycle comparison away from the edge
    always @(posedge clk) begin
        #3;
        if (rst_n && !finished) begin
            bit [31:0] st;
            vectors++;
            if (card_req !== m_busy) begin
                fails++; $display("FAIL R1 card_req actual %0b expected %0b", card_req, m_busy);
            end else if (m_busy && (card_idx !== m_idx || card_arg !== m_argl)) begin
                fails++; $display("FAIL R1 card_idx/arg actual %h/%h expected %h/%h",
                                  card_idx, card_arg, m_idx, m_argl);
            end
            if (rd_data !== m_read(int'(rd_addr))) begin
                fails++; $display("FAIL R2 rd_data @%0d actual %h expected %h",
                                  rd_addr, rd_data, m_read(int'(rd_addr)));
            end
            st = m_read(6);
            for (int k = 0; k < NIRQ; k++)
                if (irq[k] !== ((st & m_mask[k]) != 0)) begin
                    fails++; $display("FAIL R10 irq[%0d] actual %0b expected %0b",
                                      k, irq[k], (st & m_mask[k]) != 0);
                end
        end
    end

    task automatic wr(int a, bit [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack(bit e, int n, bit [127:0] r);
        @(negedge clk);
        card_ack = 1'b1; card_err = e; card_len = LW'(n); card_rsp = r;
        @(negedge clk);
        card_ack = 1'b0;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_rd(string tag, int a, bit [31:0] exp);
        @(negedge clk);
        rd_addr = AW'(a);
        #1;
        chk(tag, rd_data, exp);
    endtask

    localparam bit [127:0] RSP_A = 128'h11223344_55667788_99AABBCC_DDEEFF01;
    localparam bit [127:0] RSP_B = 128'hCAFEF00D_01020304_A0B0C0D0_0000000F;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk_rd("R11 status", 6, 32'h0);
        chk_rd("R11 cmd", 1, 32'h0);
        chk("R11 card_req", 32'(card_req), 32'h0);
        chk("R11 irq", 32'(irq), 32'h0);
        chk_rd("R1 unmapped addr", 15, 32'h0);

        wr(8, 32'h0000_0080);
        wr(9, 32'h0000_0804);
        // R1/R2/R3 no-response command
        wr(0, 32'hA5A5_0001);
        wr(1, 32'h0000_0405);
        @(negedge clk);
        chk("R1 card_req", 32'(card_req), 32'h1);
        chk("R1 card_idx", 32'(card_idx), 32'h5);
        chk("R1 card_arg", card_arg, 32'hA5A5_0001);
        chk_rd("R2 busy status", 6, 32'h0000_0800);
        chk("R10 irq busy", 32'(irq), 32'h2);
        wr(1, 32'h0000_0409);
        chk("R3 idx unchanged", 32'(card_idx), 32'h5);
        chk_rd("R3 cmd unchanged", 1, 32'h0000_0405);
        ack(1'b0, 0, '0);
        chk_rd("R4 sent bit", 6, 32'h0000_0080);
        chk_rd("R2 go cleared", 1, 32'h0000_0005);
        chk("R2 req dropped", 32'(card_req), 32'h0);
        chk("R10 irq sent", 32'(irq), 32'h1);
        // R9 clear
        wr(7, 32'hFFFF_F87F);
        chk_rd("R9 high bits ignored", 6, 32'h0000_0080);
        wr(7, 32'h0000_0080);
        chk_rd("R9 cleared", 6, 32'h0);
        // R6 short response
        wr(1, 32'h0000_0451);
        ack(1'b0, 4, RSP_A);
        chk_rd("R6 status", 6, 32'h0000_0040);
        chk_rd("R6 word0", 2, 32'h1122_3344);
        chk_rd("R6 word1", 3, 32'h0);
        chk_rd("R6 word3", 5, 32'h0);
        wr(7, 32'h7FF);
        // R7 long response
        wr(1, 32'h0000_04C2);
        ack(1'b0, 16, RSP_A);
        chk_rd("R7 word0", 2, 32'h1122_3344);
        chk_rd("R7 word2", 4, 32'h99AA_BBCC);
        chk_rd("R7 word3 bit0", 5, 32'hDDEE_FF00);
        wr(1, 32'h0000_0443);
        ack(1'b0, 16, RSP_B);
        chk_rd("R7 short req long len", 3, 32'h0102_0304);
        chk_rd("R7 word3", 5, 32'h0000_000E);
        wr(7, 32'h7FF);
        // R5 timeouts leave responses unchanged
        wr(1, 32'h0000_0444); ack(1'b1, 4, RSP_A);
        chk_rd("R5 err", 6, 32'h4);
        wr(7, 32'h7FF);
        wr(1, 32'h0000_0444); ack(1'b0, 0, RSP_A);
        chk_rd("R5 len0", 6, 32'h4);
        wr(7, 32'h7FF);
        wr(1, 32'h0000_04C4); ack(1'b0, 4, RSP_A);
        chk_rd("R5 long len4", 6, 32'h4);
        wr(7, 32'h7FF);
        wr(1, 32'h0000_0444); ack(1'b0, 8, RSP_A);
        chk_rd("R5 len8", 6, 32'h4);
        wr(1, 32'h0000_0444); ack(1'b0, 17, RSP_A);
        chk_rd("R5 word0 kept", 2, 32'hCAFE_F00D);
        wr(7, 32'h7FF);
        // R4 no response with error
        wr(1, 32'h0000_0406); ack(1'b1, 4, RSP_A);
        chk_rd("R4 timeout", 6, 32'h4);
        chk_rd("R4 rsp kept", 5, 32'h0000_000E);
        wr(7, 32'h7FF);
        // R8 pending and interrupt modes
        wr(1, 32'h0000_0603);
        chk("R8 no req", 32'(card_req), 32'h0);
        chk_rd("R8 cmd stored", 1, 32'h0000_0203);
        chk_rd("R8 no status", 6, 32'h0);
        wr(1, 32'h0000_0503);
        chk("R8 intr mode issues", 32'(card_req), 32'h1);
        ack(1'b0, 0, '0);
        chk_rd("R8 intr mode done", 6, 32'h80);
        // R12 stray ack
        ack(1'b0, 16, RSP_A);
        chk_rd("R12 status kept", 6, 32'h80);
        chk_rd("R12 rsp kept", 2, 32'hCAFE_F00D);
        // R9 completion beats same-cycle clear
        wr(1, 32'h0000_0407);
        @(negedge clk);
        card_ack = 1'b1; card_err = 1'b0;
        wr_en = 1'b1; wr_addr = AW'(7); wr_data = 32'h0000_0080;
        @(negedge clk);
        card_ack = 1'b0; wr_en = 1'b0;
        chk_rd("R9 set wins", 6, 32'h80);
        wr(8, 32'h0);
        chk("R10 masked off", 32'(irq), 32'h0);
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired, actual %0d cycles expected under 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule